// File: doc/BRIEF.md
# Aligned Restoring Binary Divider

This block divides one unsigned integer by another over several clock cycles and returns the integer quotient and the remainder. A one-cycle `start` pulse captures both operands. The block then works on its own until it raises `done` for a single cycle. When `done` is high, `quotient` and `remainder` carry the result, and they keep those values until the next accepted `start`.

The loop length follows the operands. A first trial subtraction catches a dividend smaller than the divisor and ends the operation at once. For any other operands the divisor is shifted up until its most significant one lines up with the dividend's most significant one. The block then runs one restoring step per bit position that the quotient can hold. Each step shifts the combined remainder/quotient register left, so the remainder ends up scaled up by the same number of places. A short run of right shifts undoes that scaling.

A zero divisor never enters the loop. It sets a divide-by-zero flag and finishes on the next cycle.

Top module: `aligned_divider`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all 0.
- R2: For any dividend and any nonzero divisor, `quotient` equals the floor of dividend/divisor and `remainder` equals dividend mod divisor in the cycle where `done` is high, and `div_zero` is 0.
- R3: When the dividend is smaller than the divisor, the result is quotient 0 and remainder equal to the dividend, and `done` is high after the second rising edge, counting the edge that samples `start` as edge 1.
- R4: A zero divisor gives `div_zero` = 1, `quotient` with every bit 1, `remainder` equal to the dividend, and `done` high right after edge 1.
- R5: For a nonzero divisor no larger than the dividend, let s be the dividend's leading-one index minus the divisor's leading-one index. `done` is then high after edge 5 + 3·s.
- R6: `done` is high for exactly one cycle. `busy` is high from edge 1 up to and including the `done` cycle, and low in the cycle after it.
- R7: A `start` pulse that arrives while `busy` is high has no effect: the result belongs to the operands captured by the first `start`.
- R8: `div_zero` returns to 0 when an operation with a nonzero divisor is accepted.
- R9: After `done`, `quotient`, `remainder` and `div_zero` hold their values until the next accepted `start`, even if the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; sampled only while idle |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | An operation is in progress (includes the done cycle) |
| done | output | 1 | One-cycle pulse when the result is valid |
| quotient | output | W | Integer quotient |
| remainder | output | W | Remainder |
| div_zero | output | 1 | The last accepted divisor was zero |

## Verification
The bench tries every dividend/divisor pair at a 5-bit width, so it covers:
- equal operands (s = 0);
- a divisor of 1 with a full-width dividend (longest alignment);
- every dividend smaller than its divisor;
- every zero divisor.

Each of these corner cases shows up a different fault:
- A wrong iteration count, or a wrong number of final right shifts, gives a remainder scaled by a power of two or a truncated quotient. This shows up most clearly at the longest alignment.
- An alignment compare that stops one place late or early breaks the cycle count in R5 and the values in R2.
- A trial step that does not restore the accumulator corrupts the remainder whenever the dividend is smaller than the divisor.
- A stray `start` injected mid-operation and inputs changed after `done` expose a design that reloads while busy or lets its outputs follow the inputs.

// File: rtl/divu_pkg.sv
package divu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRIAL,
        ST_ALIGN,
        ST_ITER,
        ST_SHR,
        ST_FIN
    } divu_state_e;

    // Per-cycle datapath commands issued by the sequencer
    typedef struct packed {
        logic load;         // capture operands
        logic align_shift;  // shift divisor copy left one place
        logic iter;         // one restoring subtract/shift step
        logic shr;          // shift scaled remainder right one place
    } divu_cmd_t;

endpackage

// File: rtl/divu_lead_one.sv
module divu_lead_one #(
    parameter int VW = 12,
    localparam int IW = $clog2(VW)
) (
    input  logic [VW-1:0] vec,
    output logic [IW-1:0] idx
);
    // Index of the highest set bit; 0 when the vector is zero
    always_comb begin
        idx = '0;
        for (int i = 0; i < VW; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/divu_datapath.sv
module divu_datapath
    import divu_pkg::*;
#(
    parameter int W = 8,
    localparam int AW = 2 * W + 2,
    localparam int IW = $clog2(AW)
) (
    input  logic         clk,
    input  logic         rst,
    input  divu_cmd_t    cmd,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         dvs_zero,
    output logic         diff_neg,
    output logic         align_more,
    output logic [W-1:0] quo_q,
    output logic [W-1:0] rem_q
);
    logic [AW-1:0] acc_q;   // accumulator X, with spare high bits and a sign bit
    logic [AW-1:0] ysh_q;   // divisor copy Y, shifted during alignment
    logic [W-1:0]  qb_q;    // quotient register B
    logic [AW-1:0] diff;
    logic [IW-1:0] acc_lead, y_lead;

    assign dvs_zero = (divisor == '0);
    assign diff     = acc_q - ysh_q;
    assign diff_neg = diff[AW-1];

    divu_lead_one #(.VW(AW)) u_lead_acc (.vec(acc_q), .idx(acc_lead));
    divu_lead_one #(.VW(AW)) u_lead_y   (.vec(ysh_q), .idx(y_lead));

    assign align_more = (y_lead < acc_lead);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ysh_q <= '0;
            qb_q  <= '0;
        end else if (cmd.load) begin
            acc_q <= {{(AW-W){1'b0}}, dividend};
            ysh_q <= {{(AW-W){1'b0}}, divisor};
            qb_q  <= dvs_zero ? '1 : '0;
        end else if (cmd.align_shift) begin
            ysh_q <= {ysh_q[AW-2:0], 1'b0};
        end else if (cmd.iter) begin
            // Long register XB shifts left; the kept value depends on the sign
            if (diff_neg) acc_q <= {acc_q[AW-2:0], qb_q[W-1]};
            else          acc_q <= {diff[AW-2:0], qb_q[W-1]};
            qb_q <= {qb_q[W-2:0], ~diff_neg};
        end else if (cmd.shr) begin
            acc_q <= {1'b0, acc_q[AW-1:1]};
        end
    end

    assign quo_q = qb_q;
    assign rem_q = acc_q[W-1:0];

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_q[AW-1]);

    // R2
    qbit_entry_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.iter |=> (qb_q[0] == !$past(diff_neg)));

endmodule

// File: rtl/divu_ctrl.sv
module divu_ctrl
    import divu_pkg::*;
#(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1) + 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      dvs_zero,
    input  logic      diff_neg,
    input  logic      align_more,
    output divu_cmd_t cmd,
    output logic      busy,
    output logic      done,
    output logic      div_zero
);
    divu_state_e st_q;
    logic [CW-1:0] cnt_q;   // shifts counted, then steps remaining
    logic [CW-1:0] p_q;     // iteration count p
    logic          dz_q;

    always_comb begin
        cmd             = '0;
        cmd.load        = (st_q == ST_IDLE) && start;
        cmd.align_shift = (st_q == ST_ALIGN) && align_more;
        cmd.iter        = (st_q == ST_ITER);
        cmd.shr         = (st_q == ST_SHR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            p_q   <= '0;
            dz_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    dz_q <= dvs_zero;
                    st_q <= dvs_zero ? ST_FIN : ST_TRIAL;
                end
                ST_TRIAL: begin
                    cnt_q <= '0;
                    st_q  <= diff_neg ? ST_FIN : ST_ALIGN;
                end
                ST_ALIGN: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (!align_more) begin
                        p_q  <= cnt_q + CW'(1);
                        st_q <= ST_ITER;
                    end
                end
                ST_ITER: begin
                    if (cnt_q == CW'(1)) begin
                        cnt_q <= p_q;
                        st_q  <= ST_SHR;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                ST_SHR: begin
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) st_q <= ST_FIN;
                end
                ST_FIN: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign done     = (st_q == ST_FIN);
    assign div_zero = dz_q;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R7
    start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |-> !cmd.load);

    // R5
    step_count_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ITER || st_q == ST_SHR) |-> (cnt_q != '0));

endmodule

// File: rtl/aligned_divider.sv
module aligned_divider
    import divu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_zero
);
    divu_cmd_t cmd;
    logic      dvs_zero, diff_neg, align_more;

    divu_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .dvs_zero   (dvs_zero),
        .diff_neg   (diff_neg),
        .align_more (align_more),
        .cmd        (cmd),
        .busy       (busy),
        .done       (done),
        .div_zero   (div_zero)
    );

    divu_datapath #(.W(W)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .dividend   (dividend),
        .divisor    (divisor),
        .dvs_zero   (dvs_zero),
        .diff_neg   (diff_neg),
        .align_more (align_more),
        .quo_q      (quotient),
        .rem_q      (remainder)
    );

    // R4
    dz_result_chk: assert property (@(posedge clk) disable iff (rst)
        (done && div_zero) |-> (quotient == '1));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

endmodule

// File: tb/aligned_divider_tb.sv
module aligned_divider_tb;
    localparam int W = 5;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero;
    logic [W-1:0] quotient, remainder;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    aligned_divider #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder),
        .div_zero(div_zero)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int msb(input int v);
        int r = 0;
        for (int i = 0; i < 32; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic do_div(input int a, input int b, input bit poke);
        int k;
        int eq, er, ek;
        @(negedge clk);
        dividend = W'(a); divisor = W'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0; k = 1;
        while (!done && k < 100) begin
            check(busy == 1'b1, "R6 busy", busy, 1);
            if (poke && k == 1) begin
                dividend = ~W'(a); divisor = W'(b + 3); start = 1'b1;  // R7 stray start
            end
            @(negedge clk);
            start = 1'b0; k++;
        end
        if (b == 0) begin
            eq = N - 1; er = a; ek = 1;
            check(div_zero == 1'b1, "R4 div_zero", div_zero, 1);
        end else begin
            eq = a / b; er = a % b;
            ek = (a < b) ? 2 : 5 + 3 * (msb(a) - msb(b));
            check(div_zero == 1'b0, "R8 div_zero", div_zero, 0);
        end
        check(int'(quotient) == eq, (b == 0) ? "R4 quotient" : (a < b) ? "R3 quotient" : "R2 quotient", quotient, eq);
        check(int'(remainder) == er, (b == 0) ? "R4 remainder" : (a < b) ? "R3 remainder" : "R2 remainder", remainder, er);
        check(k == ek, (b == 0) ? "R4 latency" : (a < b) ? "R3 latency" : "R5 latency", k, ek);
        // inputs change after done; outputs must hold (R9)
        dividend = ~W'(a); divisor = ~W'(b);
        @(negedge clk);
        check(done == 1'b0, "R6 done pulse", done, 0);
        check(busy == 1'b0, "R6 busy drop", busy, 0);
        check(int'(quotient) == eq && int'(remainder) == er, "R9 hold", quotient, eq);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && div_zero == 0, "R1 flags in reset", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && div_zero == 0, "R1 flags", busy, 0);
        check(quotient == '0 && remainder == '0, "R1 data", quotient, 0);
        // corner cases first
        do_div(N - 1, 1, 1'b0);
        do_div(7, 7, 1'b0);
        do_div(5, 0, 1'b0);
        do_div(9, 2, 1'b0);     // R8 clears after divide-by-zero
        do_div(3, 17, 1'b1);
        do_div(29, 3, 1'b1);    // R7
        // full sweep
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                do_div(a, b, ((a + b) % 5) == 0);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule